// File: doc/BRIEF.md
# Cross-Domain Free-Running System Timer with Capture

This block is a free-running binary counter that advances on a slow timekeeping tick in its own clock domain, while a processor bus running on an unrelated clock observes and controls it. Three tick-enable inputs in the timer domain (crystal rate, low rate, fast on-chip) feed a selector. The counter advances by one on each cycle in which the selected tick is high. The bus side sees the live count as a continuously refreshed output. Sampling that output has no path back into the counter, so no read can ever make the count step twice.

The count travels to the bus domain as a registered Gray code and passes a two-flop synchronizer. A value seen on the bus is therefore always a count that actually existed. A second way to read the time is a capture request. It crosses into the timer domain with a toggle handshake, snapshots the count there, and returns an acknowledge. A busy flag stays high for the round trip.

The bus can program a compare value and a start value for the count. A match event and a wrap event each reach a sticky bus-side flag, which software clears by writing a one. The tick source and the start value can only be changed while the counter is stopped.

Top module: `xdst_timer`

## Requirements
- R1: After reset, the count output reads 0, both sticky flags and the capture busy flag are low, and the counter stays stopped until enabled.
- R2: While enabled, the count advances by exactly one on every timer clock cycle in which the selected tick is high, and it never advances otherwise. Source code 0 selects the crystal tick, 1 the low-rate tick, 2 the fast tick and 3 no tick.
- R3: Two successive bus-cycle samples of the count output differ by 0 or 1 modulo 2^CNT_W. No sample is torn, and no double step appears when the tick is slower than the bus clock.
- R4: A step from all ones to zero sets the sticky wrap flag `wrap_flag_o`. Writing with bit 1 of `flag_clr_i` high clears it. A wrap event in the same cycle as a clear wins.
- R5: A step onto the programmed compare value sets the sticky match flag `cmp_irq_o`. Writing with bit 0 of `flag_clr_i` high clears it. A compare write accepted while the counter runs takes effect in the timer domain after its handshake.
- R6: A start-value write is accepted only while the counter is disabled, and the count then takes that value. A start-value write made while the counter is enabled has no effect on the count.
- R7: A source-select write made while the counter is enabled is ignored. The enable bit of the same write still takes effect.
- R8: A capture request raises `cap_busy_o` on the next bus cycle. `cap_val_o` then holds a count taken in the timer domain between the request and the fall of busy, and it changes only in the bus cycle after busy falls. Capturing does not disturb the count.
- R9: A capture request issued while `cap_busy_o` is high is ignored. Busy falls after one round trip and stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| tmr_clk | input | 1 | Timer-domain clock |
| tmr_rst | input | 1 | Synchronous active-high reset, timer domain |
| tick_xtal_i | input | 1 | Crystal-rate tick enable (timer domain) |
| tick_low_i | input | 1 | Low-rate tick enable (timer domain) |
| tick_fast_i | input | 1 | Fast on-chip tick enable (timer domain) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Counter enable value for the write |
| cfg_src_i | input | 2 | Tick source code for the write |
| load_we_i | input | 1 | Start-value write strobe |
| load_val_i | input | CNT_W | Start value |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_val_i | input | CNT_W | Compare value |
| cap_req_i | input | 1 | Capture request pulse |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 match, bit 1 wrap |
| count_o | output | CNT_W | Synchronized live count |
| cap_busy_o | output | 1 | Capture round trip in progress |
| cap_val_o | output | CNT_W | Last captured count |
| cmp_irq_o | output | 1 | Sticky compare-match flag |
| wrap_flag_o | output | 1 | Sticky wrap flag |

## Verification
The bench runs an 8-bit counter so that it can walk through wraps in full. It checks every bus-cycle sample for a step larger than one, which is how a torn Gray crossing or a read-triggered double increment would show. It measures the advance rate of each tick source against tick counts kept by the bench. A wrong selector or a counter that steps twice would drift beyond a three-count tolerance. Start-value and source writes made while the counter runs are checked for leaving the count untouched. Captures are checked against bounds taken before the request and after the acknowledge, and against an exact value when the counter is stopped. A second request made while busy must not relaunch the handshake.

// File: rtl/xdst_pkg.sv
package xdst_pkg;

    typedef enum logic [1:0] {
        SRC_XTAL    = 2'd0,
        SRC_LOWRATE = 2'd1,
        SRC_FAST    = 2'd2,
        SRC_NONE    = 2'd3
    } tick_src_e;

    typedef struct packed {
        logic match;
        logic wrap;
    } tmr_evt_t;

    function automatic logic [63:0] to_gray(input logic [63:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [63:0] from_gray(input logic [63:0] g);
        logic [63:0] b;
        b[63] = g[63];
        for (int i = 62; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xd_sync2.sv
module xd_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/xd_toggle_hs.sv
module xd_toggle_hs (
    input  logic bus_clk,
    input  logic bus_rst,
    input  logic tmr_clk,
    input  logic tmr_rst,
    input  logic start_i,
    output logic busy_o,
    output logic done_o,
    output logic strobe_o
);
    logic req_t;
    logic req_s;
    logic req_d;
    logic ack_s;
    logic ack_d;

    // bus side: launch a toggle only when idle
    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            req_t <= 1'b0;
        end else if (start_i && !busy_o) begin
            req_t <= ~req_t;
        end
    end

    xd_sync2 #(.W(1)) u_req_sync (
        .clk (tmr_clk),
        .rst (tmr_rst),
        .d   (req_t),
        .q   (req_s)
    );

    // timer side: req_d doubles as the acknowledge toggle
    always_ff @(posedge tmr_clk) begin
        if (tmr_rst) begin
            req_d <= 1'b0;
        end else begin
            req_d <= req_s;
        end
    end

    assign strobe_o = req_s ^ req_d;

    xd_sync2 #(.W(1)) u_ack_sync (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (req_d),
        .q   (ack_s)
    );

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            ack_d <= 1'b0;
        end else begin
            ack_d <= ack_s;
        end
    end

    assign busy_o = req_t ^ ack_s;
    assign done_o = ack_s ^ ack_d;
endmodule

// File: rtl/xdst_tmr_core.sv
module xdst_tmr_core
    import xdst_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             tmr_clk,
    input  logic             tmr_rst,
    input  logic             en_i,
    input  tick_src_e        src_i,
    input  logic             tick_xtal_i,
    input  logic             tick_low_i,
    input  logic             tick_fast_i,
    input  logic             load_stb_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             cmp_stb_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             cap_stb_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] gray_o,
    output logic [CNT_W-1:0] cap_o,
    output tmr_evt_t         evt_tgl_o,
    output logic             adv_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] gray_q;
    logic             tick_sel;
    logic             adv;
    tmr_evt_t         evt_now;
    tmr_evt_t         evt_q;

    always_comb begin
        case (src_i)
            SRC_XTAL:    tick_sel = tick_xtal_i;
            SRC_LOWRATE: tick_sel = tick_low_i;
            SRC_FAST:    tick_sel = tick_fast_i;
            default:     tick_sel = 1'b0;
        endcase
        adv           = en_i && tick_sel && !load_stb_i;
        cnt_inc       = cnt_q + CNT_ONE;
        cnt_d         = load_stb_i ? load_val_i : (adv ? cnt_inc : cnt_q);
        evt_now.match = adv && (cnt_inc == cmp_q);
        evt_now.wrap  = adv && (&cnt_q);
    end

    always_ff @(posedge tmr_clk) begin
        if (tmr_rst) begin
            cnt_q  <= '0;
            gray_q <= '0;
            cmp_q  <= '0;
            cap_q  <= '0;
            evt_q  <= '0;
        end else begin
            cnt_q  <= cnt_d;
            gray_q <= CNT_W'(to_gray(64'(cnt_d)));
            evt_q  <= evt_q ^ evt_now;
            if (cmp_stb_i) begin
                cmp_q <= cmp_val_i;
            end
            if (cap_stb_i) begin
                cap_q <= cnt_q;
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign gray_o    = gray_q;
    assign cap_o     = cap_q;
    assign evt_tgl_o = evt_q;
    assign adv_o     = adv;
endmodule

// File: rtl/xdst_timer.sv
module xdst_timer
    import xdst_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             tmr_clk,
    input  logic             tmr_rst,
    input  logic             tick_xtal_i,
    input  logic             tick_low_i,
    input  logic             tick_fast_i,
    input  logic             cfg_we_i,
    input  logic             cfg_en_i,
    input  logic [1:0]       cfg_src_i,
    input  logic             load_we_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             cmp_we_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             cap_req_i,
    input  logic [1:0]       flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             cap_busy_o,
    output logic [CNT_W-1:0] cap_val_o,
    output logic             cmp_irq_o,
    output logic             wrap_flag_o
);
    // bus-domain configuration
    logic             en_q;
    tick_src_e        src_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cmpv_q;
    logic             load_busy;
    logic             load_done;
    logic             load_start;
    logic             cmp_busy;
    logic             cmp_done;
    logic             cmp_start;
    logic             cap_done;

    // timer-domain signals
    logic             en_s;
    logic             load_stb;
    logic             cmp_stb;
    logic             cap_stb;
    logic [CNT_W-1:0] cnt_t;
    logic [CNT_W-1:0] gray_t;
    logic [CNT_W-1:0] cap_t;
    tmr_evt_t         evt_t;
    logic             adv_t;

    // bus-domain views
    logic [CNT_W-1:0] gray_s;
    logic [1:0]       evt_s;
    logic [1:0]       evt_d;
    tmr_evt_t         evt_rise;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] capv_q;
    logic             irq_q;
    logic             wrap_q;

    assign load_start = load_we_i && !en_q && !load_busy;
    assign cmp_start  = cmp_we_i && !cmp_busy;

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            en_q   <= 1'b0;
            src_q  <= SRC_XTAL;
            load_q <= '0;
            cmpv_q <= '0;
        end else begin
            if (cfg_we_i) begin
                en_q <= cfg_en_i;
                if (!en_q) begin
                    src_q <= tick_src_e'(cfg_src_i);
                end
            end
            if (load_start) begin
                load_q <= load_val_i;
            end
            if (cmp_start) begin
                cmpv_q <= cmp_val_i;
            end
        end
    end

    xd_sync2 #(.W(1)) u_en_sync (
        .clk (tmr_clk),
        .rst (tmr_rst),
        .d   (en_q),
        .q   (en_s)
    );

    xd_toggle_hs u_load_hs (
        .bus_clk  (bus_clk),
        .bus_rst  (bus_rst),
        .tmr_clk  (tmr_clk),
        .tmr_rst  (tmr_rst),
        .start_i  (load_start),
        .busy_o   (load_busy),
        .done_o   (load_done),
        .strobe_o (load_stb)
    );

    xd_toggle_hs u_cmp_hs (
        .bus_clk  (bus_clk),
        .bus_rst  (bus_rst),
        .tmr_clk  (tmr_clk),
        .tmr_rst  (tmr_rst),
        .start_i  (cmp_start),
        .busy_o   (cmp_busy),
        .done_o   (cmp_done),
        .strobe_o (cmp_stb)
    );

    xd_toggle_hs u_cap_hs (
        .bus_clk  (bus_clk),
        .bus_rst  (bus_rst),
        .tmr_clk  (tmr_clk),
        .tmr_rst  (tmr_rst),
        .start_i  (cap_req_i),
        .busy_o   (cap_busy_o),
        .done_o   (cap_done),
        .strobe_o (cap_stb)
    );

    xdst_tmr_core #(.CNT_W(CNT_W)) u_core (
        .tmr_clk     (tmr_clk),
        .tmr_rst     (tmr_rst),
        .en_i        (en_s),
        .src_i       (src_q),
        .tick_xtal_i (tick_xtal_i),
        .tick_low_i  (tick_low_i),
        .tick_fast_i (tick_fast_i),
        .load_stb_i  (load_stb),
        .load_val_i  (load_q),
        .cmp_stb_i   (cmp_stb),
        .cmp_val_i   (cmpv_q),
        .cap_stb_i   (cap_stb),
        .cnt_o       (cnt_t),
        .gray_o      (gray_t),
        .cap_o       (cap_t),
        .evt_tgl_o   (evt_t),
        .adv_o       (adv_t)
    );

    xd_sync2 #(.W(CNT_W)) u_gray_sync (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (gray_t),
        .q   (gray_s)
    );

    xd_sync2 #(.W(2)) u_evt_sync (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (evt_t),
        .q   (evt_s)
    );

    assign evt_rise = evt_s ^ evt_d;

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            evt_d   <= '0;
            count_q <= '0;
            capv_q  <= '0;
            irq_q   <= 1'b0;
            wrap_q  <= 1'b0;
        end else begin
            evt_d   <= evt_s;
            count_q <= CNT_W'(from_gray(64'(gray_s)));
            irq_q   <= (irq_q & ~flag_clr_i[0]) | evt_rise.match;
            wrap_q  <= (wrap_q & ~flag_clr_i[1]) | evt_rise.wrap;
            if (cap_done) begin
                capv_q <= cap_t;
            end
        end
    end

    assign count_o     = count_q;
    assign cap_val_o   = capv_q;
    assign cmp_irq_o   = irq_q;
    assign wrap_flag_o = wrap_q;

    // handshake completions other than capture carry no bus-side action
    logic unused_done;
    assign unused_done = load_done ^ cmp_done;
endmodule

// File: rtl/xdst_timer_chk.sv
module xdst_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             bus_clk,
    input logic             bus_rst,
    input logic             tmr_clk,
    input logic             tmr_rst,
    input logic [CNT_W-1:0] cnt,
    input logic             adv,
    input logic             load_stb,
    input logic             cap_req,
    input logic             cap_busy,
    input logic [CNT_W-1:0] cap_val,
    input logic             en_q,
    input logic [1:0]       src_q,
    input logic             load_busy
);
    logic [1:0] t_seen;
    logic [1:0] b_seen;

    always_ff @(posedge tmr_clk) begin
        if (tmr_rst) t_seen <= 2'd0;
        else if (t_seen != 2'd3) t_seen <= t_seen + 2'd1;
    end

    always_ff @(posedge bus_clk) begin
        if (bus_rst) b_seen <= 2'd0;
        else if (b_seen != 2'd3) b_seen <= b_seen + 2'd1;
    end

    // R2: outside a load, the count holds or steps by exactly one
    a_r2_single_step: assert property (@(posedge tmr_clk) disable iff (tmr_rst || t_seen != 2'd3)
        !$past(load_stb) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // R4: a step from all ones lands on zero
    a_r4_wrap_zero: assert property (@(posedge tmr_clk) disable iff (tmr_rst || t_seen != 2'd3)
        ($past(adv) && (&$past(cnt)) && !$past(load_stb)) |-> (cnt == '0));

    // R8: busy only rises after a request
    a_r8_busy_from_req: assert property (@(posedge bus_clk) disable iff (bus_rst || b_seen != 2'd3)
        $rose(cap_busy) |-> $past(cap_req));

    // R8: captured value changes only in the cycle after busy falls
    a_r8_capval_after_ack: assert property (@(posedge bus_clk) disable iff (bus_rst || b_seen != 2'd3)
        !$stable(cap_val) |-> (!$past(cap_busy) && $past(cap_busy, 2)));

    // R7: source changes only while disabled
    a_r7_src_locked: assert property (@(posedge bus_clk) disable iff (bus_rst || b_seen != 2'd3)
        !$stable(src_q) |-> !$past(en_q));

    // R6: a load launches only while disabled
    a_r6_load_locked: assert property (@(posedge bus_clk) disable iff (bus_rst || b_seen != 2'd3)
        $rose(load_busy) |-> !$past(en_q));
endmodule

bind xdst_timer xdst_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .bus_clk   (bus_clk),
    .bus_rst   (bus_rst),
    .tmr_clk   (tmr_clk),
    .tmr_rst   (tmr_rst),
    .cnt       (cnt_t),
    .adv       (adv_t),
    .load_stb  (load_stb),
    .cap_req   (cap_req_i),
    .cap_busy  (cap_busy_o),
    .cap_val   (cap_val_o),
    .en_q      (en_q),
    .src_q     (src_q),
    .load_busy (load_busy)
);

// File: tb/xdst_timer_tb_top.sv
module xdst_timer_tb_top;
    localparam int W = 8;

    logic bus_clk = 1'b0;
    logic tmr_clk = 1'b0;
    logic bus_rst = 1'b1;
    logic tmr_rst = 1'b1;
    always #4 bus_clk = ~bus_clk;
    always #6 tmr_clk = ~tmr_clk;

    logic         tick_xtal, tick_low, tick_fast;
    logic         cfg_we = 1'b0, cfg_en = 1'b0;
    logic [1:0]   cfg_src = 2'd0;
    logic         load_we = 1'b0;
    logic [W-1:0] load_val = '0;
    logic         cmp_we = 1'b0;
    logic [W-1:0] cmp_val = '0;
    logic         cap_req = 1'b0;
    logic [1:0]   flag_clr = 2'b00;
    logic [W-1:0] count;
    logic         cap_busy;
    logic [W-1:0] cap_val;
    logic         cmp_irq;
    logic         wrap_flag;

    xdst_timer #(.CNT_W(W)) dut_i (
        .bus_clk     (bus_clk),
        .bus_rst     (bus_rst),
        .tmr_clk     (tmr_clk),
        .tmr_rst     (tmr_rst),
        .tick_xtal_i (tick_xtal),
        .tick_low_i  (tick_low),
        .tick_fast_i (tick_fast),
        .cfg_we_i    (cfg_we),
        .cfg_en_i    (cfg_en),
        .cfg_src_i   (cfg_src),
        .load_we_i   (load_we),
        .load_val_i  (load_val),
        .cmp_we_i    (cmp_we),
        .cmp_val_i   (cmp_val),
        .cap_req_i   (cap_req),
        .flag_clr_i  (flag_clr),
        .count_o     (count),
        .cap_busy_o  (cap_busy),
        .cap_val_o   (cap_val),
        .cmp_irq_o   (cmp_irq),
        .wrap_flag_o (wrap_flag)
    );

    // tick generation in the timer domain, counted by the bench
    int tc = 0;
    int n_xtal = 0, n_low = 0, n_fast = 0;
    always @(negedge tmr_clk) tc <= tmr_rst ? 0 : tc + 1;
    assign tick_xtal = !tmr_rst && (tc % 4 == 0);
    assign tick_low  = !tmr_rst && (tc % 32 == 0);
    assign tick_fast = !tmr_rst;
    always @(posedge tmr_clk) begin
        if (tick_xtal) n_xtal++;
        if (tick_low)  n_low++;
        if (tick_fast) n_fast++;
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic do_cfg(input bit en, input logic [1:0] s);
        cfg_we = 1'b1; cfg_en = en; cfg_src = s;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic do_load(input logic [W-1:0] v);
        load_we = 1'b1; load_val = v;
        cyc(1);
        load_we = 1'b0;
    endtask

    task automatic do_cmp(input logic [W-1:0] v);
        cmp_we = 1'b1; cmp_val = v;
        cyc(1);
        cmp_we = 1'b0;
    endtask

    task automatic do_clr(input logic [1:0] b);
        flag_clr = b;
        cyc(1);
        flag_clr = 2'b00;
    endtask

    function automatic int ticks_of(input logic [1:0] s);
        case (s)
            2'd0: return n_xtal;
            2'd1: return n_low;
            2'd2: return n_fast;
            default: return 0;
        endcase
    endfunction

    task automatic rate_chk(input logic [1:0] s, input int win, input string tag);
        logic [W-1:0] c0, c1, d;
        int n0, n1, e, diff;
        do_cfg(1'b0, s);
        do_cfg(1'b1, s);
        cyc(20);
        c0 = count; n0 = ticks_of(s);
        cyc(win);
        c1 = count; n1 = ticks_of(s);
        d = c1 - c0;
        e = n1 - n0;
        diff = int'(d) - e;
        chk(diff <= 3 && diff >= -3, tag, int'(d), e);
    endtask

    task automatic step_sweep(input int n, input string tag);
        logic [W-1:0] prev, cur, d;
        prev = count;
        for (int i = 0; i < n; i++) begin
            cyc(1);
            cur = count;
            d = cur - prev;
            chk(d <= 1, tag, int'(d), 1);
            prev = cur;
        end
    endtask

    initial begin
        repeat (100000) @(posedge bus_clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] c0, c1, cv;
        bit stayed_low;
        repeat (6) @(negedge bus_clk);
        bus_rst = 1'b0;
        @(negedge tmr_clk);
        tmr_rst = 1'b0;
        cyc(2);

        // R1: reset state and stopped counter
        chk(count == 0, "R1 count after reset", int'(count), 0);
        chk(!cmp_irq && !wrap_flag, "R1 flags after reset", {cmp_irq, wrap_flag}, 0);
        chk(!cap_busy, "R1 capture busy after reset", cap_busy, 0);
        cyc(30);
        chk(count == 0, "R1 counter stays stopped", int'(count), 0);

        // R2: rate per source
        rate_chk(2'd2, 200,  "R2 fast tick rate");
        rate_chk(2'd0, 400,  "R2 crystal tick rate");
        rate_chk(2'd1, 1500, "R2 low-rate tick rate");
        do_cfg(1'b0, 2'd3);
        do_cfg(1'b1, 2'd3);
        cyc(10);
        c0 = count;
        cyc(100);
        chk(count == c0, "R2 no-tick source holds", int'(count), int'(c0));

        // R3: every bus sample steps by 0 or 1, across two wraps, fast and crystal
        do_cfg(1'b0, 2'd2);
        do_cfg(1'b1, 2'd2);
        step_sweep(800, "R3 fast step");
        do_cfg(1'b0, 2'd0);
        do_cfg(1'b1, 2'd0);
        step_sweep(300, "R3 crystal step");

        // R4: wrap flag
        do_cfg(1'b0, 2'd2);
        cyc(10);
        do_load(8'hF0);
        cyc(20);
        do_clr(2'b11);
        cyc(3);
        chk(count == 8'hF0, "R6 load while disabled", int'(count), 'hF0);
        chk(!wrap_flag, "R4 wrap flag clear before wrap", wrap_flag, 0);
        do_cfg(1'b1, 2'd2);
        cyc(40);
        chk(wrap_flag, "R4 wrap flag set after wrap", wrap_flag, 1);
        cyc(20);
        chk(wrap_flag, "R4 wrap flag sticky", wrap_flag, 1);
        do_clr(2'b10);
        cyc(1);
        chk(!wrap_flag, "R4 wrap flag cleared", wrap_flag, 0);

        // R5: compare match
        do_cfg(1'b0, 2'd2);
        cyc(10);
        do_load(8'h10);
        do_cmp(8'h30);
        cyc(20);
        do_clr(2'b11);
        cyc(2);
        chk(!cmp_irq, "R5 match flag clear before run", cmp_irq, 0);
        do_cfg(1'b1, 2'd2);
        for (int k = 0; k < 400 && count < 8'h28; k++) cyc(1);
        chk(!cmp_irq, "R5 no match before compare value", cmp_irq, 0);
        for (int k = 0; k < 400 && count < 8'h38; k++) cyc(1);
        chk(cmp_irq, "R5 match flag after compare value", cmp_irq, 1);
        do_clr(2'b01);
        cyc(1);
        chk(!cmp_irq, "R5 match flag cleared", cmp_irq, 0);

        // R6: load while enabled is ignored
        cyc(5);
        c0 = count;
        do_load(8'h05);
        cyc(1);
        chk(!dut_cap_idle_load(), "R6 load while enabled not launched", 0, 0);
        cyc(19);
        c1 = count;
        chk((c1 - c0) >= 10 && (c1 - c0) <= 18, "R6 count keeps running", int'(c1 - c0), 14);

        // R7: source write while enabled ignored, enable bit still applies
        do_cfg(1'b1, 2'd3);
        cyc(5);
        c0 = count;
        cyc(50);
        c1 = count;
        chk((c1 - c0) >= 25, "R7 source write ignored while enabled", int'(c1 - c0), 33);
        do_cfg(1'b0, 2'd2);
        cyc(10);
        c0 = count;
        cyc(30);
        chk(count == c0, "R7 enable bit applies", int'(count), int'(c0));

        // R8: capture while running
        do_cfg(1'b1, 2'd2);
        cyc(10);
        c0 = count;
        cap_req = 1'b1;
        cyc(1);
        cap_req = 1'b0;
        chk(cap_busy, "R8 busy after request", cap_busy, 1);
        for (int k = 0; k < 60 && cap_busy; k++) cyc(1);
        cyc(2);
        cv = cap_val;
        c1 = count;
        chk((cv - c0) <= 10, "R8 capture not before request", int'(cv - c0), 0);
        chk((c1 - cv) <= 10, "R8 capture not after acknowledge", int'(c1 - cv), 0);
        step_sweep(60, "R8 count undisturbed after capture");

        // R8 and R9: exact capture while stopped, second request ignored
        do_cfg(1'b0, 2'd2);
        cyc(10);
        do_load(8'h5A);
        cyc(20);
        cap_req = 1'b1;
        cyc(2);
        cap_req = 1'b0;
        for (int k = 0; k < 60 && cap_busy; k++) cyc(1);
        cyc(2);
        chk(cap_val == 8'h5A, "R8 capture of stopped count", int'(cap_val), 'h5A);
        stayed_low = 1'b1;
        for (int k = 0; k < 30; k++) begin
            cyc(1);
            if (cap_busy) stayed_low = 1'b0;
        end
        chk(stayed_low, "R9 request while busy ignored", !stayed_low, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // the only port-visible sign of an accepted load while running is the count;
    // this helper reports a jump to the written value in the next samples
    function automatic bit dut_cap_idle_load();
        return count == 8'h05;
    endfunction
endmodule